// File: doc/BRIEF.md
# Reset and Stop Recovery Counter

This block times the oscillator settling that the chip needs after power comes up, after a supply-droop reset, and after wakeup from stop mode. It has one 12-bit counter that advances on the falling edge of the oscillator clock. A small state machine reuses that counter in three ways:

- as a two-phase sequencer that releases the internal reset first and the CPU reset later;
- as a stop-wakeup delay, long or short;
- as a prescaler whose overflow drives a watchdog.

A supply-droop request or a power-on request holds the block in reset. When the request goes away, the counter runs a long window and then releases the internal reset and enables the bus clocks. A further short window releases the CPU, so that it can fetch its reset vector.

A stop strobe stops the bus clocks and clears the counter. A wakeup event then starts either a long or a short settling delay, chosen by a configuration bit. In normal running, the counter is free-running and its wrap produces a single-cycle watchdog tick.

Top module: `recovery_sequencer`

## Requirements
- R1: While `por_req` is high, and on the first sample after it, `int_rst` and `cpu_rst` are 1 and `bus_clk_en` and `wdog_tick` are 0.
- R2: Once the reset request (`por_req` or `lv_req`) is low, `int_rst` stays 1 for 4095 falling edges of `osc_clk` and drops after the 4096th. `bus_clk_en` is 0 while `int_rst` is 1.
- R3: `bus_clk_en` rises together with the fall of `int_rst`. `cpu_rst` falls 64 falling edges after `int_rst` falls, and never before it.
- R4: An `lv_req` that is sampled high clears the counter and returns the block to the start of the reset sequence, from any state. This includes the middle of a sequence already running.
- R5: In normal running, a sampled `stop_strobe` drives `bus_clk_en` to 0 at that same edge and clears the counter. `bus_clk_en` stays 0 until wakeup recovery ends.
- R6: A `wake_evt` sampled with `short_rec` = 0 enables the bus clocks 4096 falling edges after the wake edge.
- R7: A `wake_evt` sampled with `short_rec` = 1 enables the bus clocks 32 falling edges after the wake edge. Changing `short_rec` after the wake edge has no effect on the delay.
- R8: In normal running, `wdog_tick` is a one-cycle pulse once every 4096 falling edges. The first pulse comes on the 4096th edge after normal running begins.
- R9: A reset request on the same edge as the end of stop recovery wins. The bus clocks stay off and the full reset sequence starts.
- R10: `wdog_tick` is 0 in every state except normal running, including the edge on which a long recovery ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock; all state changes on its falling edge |
| por_req | input | 1 | Power-on reset request, synchronous, active high |
| lv_req | input | 1 | Low-supply reset request, level, active high |
| stop_strobe | input | 1 | One-cycle stop-entry strobe |
| wake_evt | input | 1 | Wakeup event that ends stop mode |
| short_rec | input | 1 | 1 selects the short stop recovery delay |
| bus_clk_en | output | 1 | Enable for the internal bus clocks |
| int_rst | output | 1 | Internal reset, active high |
| cpu_rst | output | 1 | CPU reset, active high, released last |
| wdog_tick | output | 1 | Watchdog prescaler pulse on counter wrap |

## Verification
The end of stop recovery and a new reset request can land on the same falling edge. Both want to change the counter and the bus clock enable in that cycle. The bench provokes this by raising `lv_req` on exactly the edge at which the short recovery would finish. It judges the outcome by checking three things: `bus_clk_en` stays low, `int_rst` stays high, and the release then takes a full 4096 edges. A second test pulses `lv_req` partway through a reset hold and checks that the release count restarts from zero.

// File: rtl/recovery_pkg.sv
package recovery_pkg;
  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_STOPPED   = 3'd1,
    ST_REC_LONG  = 3'd2,
    ST_REC_SHORT = 3'd3,
    ST_RST_HOLD  = 3'd4,
    ST_RST_TAIL  = 3'd5
  } rec_state_t;
endpackage

// File: rtl/recovery_counter.sv
module recovery_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(negedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/recovery_ctrl.sv
module recovery_ctrl
  import recovery_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int LONG_CYC  = 4096,
  parameter int SHORT_CYC = 32,
  parameter int TAIL_CYC  = 64
) (
  input  logic             clk,
  input  logic             por_req,
  input  logic             lv_req,
  input  logic             stop_strobe,
  input  logic             wake_evt,
  input  logic             short_rec,
  input  logic [CNT_W-1:0] cnt,
  output logic             cnt_clr,
  output logic             cnt_en,
  output rec_state_t       state,
  output logic             bus_clk_en,
  output logic             int_rst,
  output logic             cpu_rst,
  output logic             wdog_tick
);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYC - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] TAIL_LAST  = CNT_W'(TAIL_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_MAX    = '1;

  rec_state_t nxt;
  logic       tick_d;

  always_comb begin
    nxt     = state;
    cnt_clr = 1'b0;
    cnt_en  = 1'b1;
    tick_d  = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (stop_strobe) begin
          nxt     = ST_STOPPED;
          cnt_clr = 1'b1;
        end else begin
          tick_d = (cnt == CNT_MAX);
        end
      end
      ST_STOPPED: begin
        cnt_en  = 1'b0;
        cnt_clr = 1'b1;
        if (wake_evt) nxt = short_rec ? ST_REC_SHORT : ST_REC_LONG;
      end
      ST_REC_LONG: begin
        if (cnt == LONG_LAST) begin
          nxt     = ST_RUN;
          cnt_clr = 1'b1;
        end
      end
      ST_REC_SHORT: begin
        if (cnt == SHORT_LAST) begin
          nxt     = ST_RUN;
          cnt_clr = 1'b1;
        end
      end
      ST_RST_HOLD: begin
        if (cnt == LONG_LAST) begin
          nxt     = ST_RST_TAIL;
          cnt_clr = 1'b1;
        end
      end
      ST_RST_TAIL: begin
        if (cnt == TAIL_LAST) begin
          nxt     = ST_RUN;
          cnt_clr = 1'b1;
        end
      end
      default: begin
        nxt     = ST_RST_HOLD;
        cnt_clr = 1'b1;
      end
    endcase
    if (lv_req) begin
      nxt     = ST_RST_HOLD;
      cnt_clr = 1'b1;
      tick_d  = 1'b0;
    end
  end

  always_ff @(negedge clk) begin
    if (por_req) begin
      state      <= ST_RST_HOLD;
      int_rst    <= 1'b1;
      cpu_rst    <= 1'b1;
      bus_clk_en <= 1'b0;
      wdog_tick  <= 1'b0;
    end else begin
      state      <= nxt;
      int_rst    <= (nxt == ST_RST_HOLD);
      cpu_rst    <= (nxt == ST_RST_HOLD) || (nxt == ST_RST_TAIL);
      bus_clk_en <= (nxt == ST_RUN) || (nxt == ST_RST_TAIL);
      wdog_tick  <= tick_d;
    end
  end

  // R8: the tick lasts exactly one cycle
  p_tick_single_r8: assert property (@(negedge clk) disable iff (por_req)
    wdog_tick |=> !wdog_tick);
  // R5: a stop taken in normal running gates the bus clocks at once
  p_stop_gates_r5: assert property (@(negedge clk) disable iff (por_req)
    (state == ST_RUN && stop_strobe && !lv_req) |=> (!bus_clk_en && state == ST_STOPPED));
endmodule

// File: rtl/recovery_sequencer.sv
module recovery_sequencer
  import recovery_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int LONG_CYC  = 4096,
  parameter int SHORT_CYC = 32,
  parameter int TAIL_CYC  = 64
) (
  input  logic osc_clk,
  input  logic por_req,
  input  logic lv_req,
  input  logic stop_strobe,
  input  logic wake_evt,
  input  logic short_rec,
  output logic bus_clk_en,
  output logic int_rst,
  output logic cpu_rst,
  output logic wdog_tick
);
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr;
  logic             cnt_en;
  rec_state_t       state;

  recovery_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk (osc_clk),
    .rst (por_req),
    .clr (cnt_clr),
    .en  (cnt_en),
    .cnt (cnt)
  );

  recovery_ctrl #(
    .CNT_W(CNT_W), .LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC), .TAIL_CYC(TAIL_CYC)
  ) u_ctrl (
    .clk         (osc_clk),
    .por_req     (por_req),
    .lv_req      (lv_req),
    .stop_strobe (stop_strobe),
    .wake_evt    (wake_evt),
    .short_rec   (short_rec),
    .cnt         (cnt),
    .cnt_clr     (cnt_clr),
    .cnt_en      (cnt_en),
    .state       (state),
    .bus_clk_en  (bus_clk_en),
    .int_rst     (int_rst),
    .cpu_rst     (cpu_rst),
    .wdog_tick   (wdog_tick)
  );

  // R3: the CPU is never released while the internal reset is active
  p_cpu_after_int_r3: assert property (@(negedge osc_clk) disable iff (por_req)
    !cpu_rst |-> !int_rst);
  // R2: no bus clock while the internal reset holds
  p_clk_off_in_rst_r2: assert property (@(negedge osc_clk) disable iff (por_req)
    int_rst |-> !bus_clk_en);
  // R4: a supply-droop request restarts the sequence from zero
  p_lv_restart_r4: assert property (@(negedge osc_clk) disable iff (por_req)
    lv_req |=> (int_rst && cnt == '0));
  // R10: ticks only while fully running
  p_tick_in_run_r10: assert property (@(negedge osc_clk) disable iff (por_req)
    wdog_tick |-> (bus_clk_en && !cpu_rst));
endmodule

// File: tb/recovery_sequencer_test.sv
module recovery_sequencer_test;
  logic clk = 1'b0;
  logic por_req = 1'b1, lv_req = 1'b0, stop_strobe = 1'b0, wake_evt = 1'b0, short_rec = 1'b0;
  logic bus_clk_en, int_rst, cpu_rst, wdog_tick;
  int   errors = 0;
  int   checks = 0;

  always #2 clk = ~clk;

  recovery_sequencer uut (
    .osc_clk(clk), .por_req(por_req), .lv_req(lv_req), .stop_strobe(stop_strobe),
    .wake_evt(wake_evt), .short_rec(short_rec), .bus_clk_en(bus_clk_en),
    .int_rst(int_rst), .cpu_rst(cpu_rst), .wdog_tick(wdog_tick)
  );

  typedef struct packed {
    logic        sr;
    logic        flip;
    logic [15:0] gap;
    logic [15:0] dly;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{sr: 1'b0, flip: 1'b0, gap: 16'd5,  dly: 16'd4096},
    '{sr: 1'b1, flip: 1'b0, gap: 16'd3,  dly: 16'd32},
    '{sr: 1'b1, flip: 1'b1, gap: 16'd0,  dly: 16'd32},
    '{sr: 1'b0, flip: 1'b1, gap: 16'd10, dly: 16'd4096}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
  endtask

  // Drops the request at the current posedge (P0) and checks both releases.
  task automatic release_seq(input string req);
    adv(4095);
    check({req, " R2 int_rst held"}, int_rst, 1'b1);
    check({req, " R2 bus off in reset"}, bus_clk_en, 1'b0);
    adv(1);
    check({req, " R2 int_rst released"}, int_rst, 1'b0);
    check({req, " R3 bus on with release"}, bus_clk_en, 1'b1);
    adv(63);
    check({req, " R3 cpu_rst held"}, cpu_rst, 1'b1);
    adv(1);
    check({req, " R3 cpu_rst released"}, cpu_rst, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    adv(3);
    check("R1 int_rst", int_rst, 1'b1);
    check("R1 cpu_rst", cpu_rst, 1'b1);
    check("R1 bus_clk_en", bus_clk_en, 1'b0);
    check("R1 wdog_tick", wdog_tick, 1'b0);
    por_req = 1'b0;
    release_seq("por");
    // running since P4160 of the release; first tick at P8256
    adv(4095);
    check("R8 no early tick", wdog_tick, 1'b0);
    adv(1);
    check("R8 first tick", wdog_tick, 1'b1);
    adv(1);
    check("R8 tick one cycle", wdog_tick, 1'b0);
    adv(4094);
    check("R8 no tick before period", wdog_tick, 1'b0);
    adv(1);
    check("R8 periodic tick", wdog_tick, 1'b1);

    for (int i = 0; i < 4; i++) begin
      stop_strobe = 1'b1;
      adv(1);
      stop_strobe = 1'b0;
      check("R5 bus off after stop", bus_clk_en, 1'b0);
      adv(int'(VECS[i].gap));
      check("R5 bus off while stopped", bus_clk_en, 1'b0);
      check("R10 no tick while stopped", wdog_tick, 1'b0);
      short_rec = VECS[i].sr;
      wake_evt  = 1'b1;
      adv(1);
      wake_evt = 1'b0;
      if (VECS[i].flip) short_rec = ~VECS[i].sr;
      adv(int'(VECS[i].dly) - 1);
      check(VECS[i].sr ? "R7 short recovery pending" : "R6 long recovery pending",
            bus_clk_en, 1'b0);
      adv(1);
      check(VECS[i].sr ? "R7 short recovery done" : "R6 long recovery done",
            bus_clk_en, 1'b1);
      check("R10 no tick at recovery end", wdog_tick, 1'b0);
      adv(2);
    end

    // R9: reset request on the recovery-end edge
    stop_strobe = 1'b1;
    adv(1);
    stop_strobe = 1'b0;
    adv(2);
    short_rec = 1'b1;
    wake_evt  = 1'b1;
    adv(1);
    wake_evt = 1'b0;
    adv(31);
    check("R9 bus off before collision", bus_clk_en, 1'b0);
    lv_req = 1'b1;
    adv(1);
    lv_req = 1'b0;
    check("R9 bus stays off", bus_clk_en, 1'b0);
    check("R9 int_rst asserted", int_rst, 1'b1);
    check("R9 cpu_rst asserted", cpu_rst, 1'b1);
    // R4: restart in the middle of the hold
    adv(2000);
    check("R4 still in hold", int_rst, 1'b1);
    lv_req = 1'b1;
    adv(1);
    lv_req = 1'b0;
    release_seq("R4 restart");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule